// File: doc/BRIEF.md
# Frame-Difference Motion Box Detector

This block takes a raster stream of luma pixels. Each beat carries the current frame's value and the value at the same position in the previous frame, which an external frame store supplies. The block takes the absolute difference of the two values. It compares that difference with a programmable threshold and emits a binary motion mask: all ones where the pixel moved and zero elsewhere. Start-of-frame, start-of-line and end-of-frame markers travel with the mask.

While the frame streams through, the block keeps the smallest rectangle that holds every motion pixel. When the last pixel of the frame is accepted, it reports the rectangle's top row, bottom row, left column and right column with a one-cycle valid strobe. If no pixel moved, it raises a no-target flag instead.

Both the pixel input and the mask output are valid/ready streams. A beat transfers on a clock edge where valid and ready are both high. A producer must hold its beat unchanged until it transfers. The input accepts a beat whenever the mask register is empty or is being drained in the same cycle. The box report is a plain strobe and cannot be stalled.

Top module: `mdet_motion_box`

## Requirements
- R1: The difference is the magnitude of current minus previous luma, so a rise and a fall of equal size give the same mask result.
- R2: A pixel whose difference is strictly greater than the threshold gives a mask value of all ones (255 at 8 bits). A difference equal to or below the threshold gives 0.
- R3: Reset sets the threshold to 15. A cycle with `thr_wr` high loads `thr_data`, and the new threshold applies to beats accepted from the next cycle onward.
- R4: The mask for an accepted beat appears in the cycle after acceptance with `mask_valid` high. `mask_sof`, `mask_sol` and `mask_eof` carry that same beat's markers.
- R5: `in_ready` is high exactly when `mask_valid` is low or `mask_ready` is high. While `mask_valid` is high and `mask_ready` is low, every mask output holds its value. Cycles without a transfer leave the mask outputs unchanged.
- R6: A beat with `in_sof` has row 0 and column 0. A beat with `in_sol` (and no `in_sof`) has the next row and column 0. Any other beat has the same row and the next column.
- R7: In the cycle after a beat with `in_eof` is accepted, `box_valid` is high for one cycle. The box outputs then give the minimum and maximum row and column over all marked pixels of the frame, the end-of-frame pixel included.
- R8: If no pixel of the frame was marked, `box_none` is high together with `box_valid`, and all four coordinates are 0.
- R9: The extents restart at each start-of-frame beat, so marks from an earlier frame never widen a later box. The box outputs and `box_none` hold their values between reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_wr | input | 1 | Load strobe for the threshold register |
| thr_data | input | PIX_W | New threshold value |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| cur_luma | input | PIX_W | Current-frame luma |
| prev_luma | input | PIX_W | Previous-frame luma at the same position |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| in_sol | input | 1 | Beat is the first pixel of a line |
| in_eof | input | 1 | Beat is the last pixel of a frame |
| mask_valid | output | 1 | Mask beat valid |
| mask_ready | input | 1 | Downstream accepts the mask beat |
| mask_data | output | PIX_W | All ones for motion, zero otherwise |
| mask_sof | output | 1 | Start-of-frame marker of the mask beat |
| mask_sol | output | 1 | Start-of-line marker of the mask beat |
| mask_eof | output | 1 | End-of-frame marker of the mask beat |
| box_valid | output | 1 | One-cycle box report strobe |
| box_none | output | 1 | Reported frame held no motion pixel |
| box_top | output | ROW_W | Smallest marked row |
| box_bottom | output | ROW_W | Largest marked row |
| box_left | output | COL_W | Smallest marked column |
| box_right | output | COL_W | Largest marked column |

## Verification
On every cycle, the assertions check that a stalled mask beat stays frozen and that the mask only turns valid after an input transfer. They also check that every reported box is ordered (top not below bottom, left not right of right), that an empty report carries zero coordinates, and that a marked pixel always lies inside the running extents. The bench scenarios are the only place to see the numbers: the threshold boundary and its default, the sign symmetry of the difference, the exact coordinates that line and frame markers produce, the inclusion of the end-of-frame pixel, and the restart of the extents from one frame to the next.

// File: rtl/mdet_pkg.sv
package mdet_pkg;

  typedef struct packed {
    logic sof;
    logic sol;
    logic eof;
  } mdet_sync_t;

endpackage

// File: rtl/mdet_thr_reg.sv
module mdet_thr_reg #(
  parameter int          PIX_W      = 8,
  parameter int unsigned DEF_THRESH = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [PIX_W-1:0] wdata,
  output logic [PIX_W-1:0] thr
);

  always_ff @(posedge clk) begin
    if (!rst_n)  thr <= PIX_W'(DEF_THRESH);
    else if (wr) thr <= wdata;
  end

endmodule

// File: rtl/mdet_absdiff_thr.sv
module mdet_absdiff_thr #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] cur,
  input  logic [PIX_W-1:0] prev,
  input  logic [PIX_W-1:0] thr,
  output logic             hit
);

  logic [PIX_W-1:0] mag;

  always_comb begin
    if (cur >= prev) mag = cur - prev;
    else             mag = prev - cur;
    hit = (mag > thr);
  end

endmodule

// File: rtl/mdet_coord.sv
module mdet_coord #(
  parameter int ROW_W = 11,
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             sof,
  input  logic             sol,
  output logic [ROW_W-1:0] pix_row,
  output logic [COL_W-1:0] pix_col
);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  always_comb begin
    if (sof) begin
      pix_row = '0;
      pix_col = '0;
    end else if (sol) begin
      pix_row = row_q + ROW_W'(1);
      pix_col = '0;
    end else begin
      pix_row = row_q;
      pix_col = col_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (step) begin
      row_q <= pix_row;
      col_q <= pix_col;
    end
  end

endmodule

// File: rtl/mdet_extent.sv
module mdet_extent #(
  parameter int ROW_W = 11,
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             sof,
  input  logic             eof,
  input  logic             hit,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic             box_valid,
  output logic             box_none,
  output logic [ROW_W-1:0] box_top,
  output logic [ROW_W-1:0] box_bottom,
  output logic [COL_W-1:0] box_left,
  output logic [COL_W-1:0] box_right
);

  logic             any_q, any_n;
  logic [ROW_W-1:0] top_q, bot_q, top_n, bot_n;
  logic [COL_W-1:0] lft_q, rgt_q, lft_n, rgt_n;

  always_comb begin
    if (sof) begin
      any_n = 1'b0;
      top_n = '1;
      bot_n = '0;
      lft_n = '1;
      rgt_n = '0;
    end else begin
      any_n = any_q;
      top_n = top_q;
      bot_n = bot_q;
      lft_n = lft_q;
      rgt_n = rgt_q;
    end
    if (hit) begin
      any_n = 1'b1;
      if (row < top_n) top_n = row;
      if (row > bot_n) bot_n = row;
      if (col < lft_n) lft_n = col;
      if (col > rgt_n) rgt_n = col;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      any_q <= 1'b0;
      top_q <= '1;
      bot_q <= '0;
      lft_q <= '1;
      rgt_q <= '0;
    end else if (step) begin
      any_q <= any_n;
      top_q <= top_n;
      bot_q <= bot_n;
      lft_q <= lft_n;
      rgt_q <= rgt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      box_valid  <= 1'b0;
      box_none   <= 1'b0;
      box_top    <= '0;
      box_bottom <= '0;
      box_left   <= '0;
      box_right  <= '0;
    end else begin
      box_valid <= step && eof;
      if (step && eof) begin
        box_none   <= !any_n;
        box_top    <= any_n ? top_n : '0;
        box_bottom <= any_n ? bot_n : '0;
        box_left   <= any_n ? lft_n : '0;
        box_right  <= any_n ? rgt_n : '0;
      end
    end
  end

  // R7
  box_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (box_valid && !box_none) |-> (box_top <= box_bottom && box_left <= box_right));

  // R8
  box_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (box_valid && box_none) |-> (box_top == '0 && box_bottom == '0 && box_left == '0 && box_right == '0));

  // R9
  extent_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hit) |=> (any_q && top_q <= $past(row) && bot_q >= $past(row)
                       && lft_q <= $past(col) && rgt_q >= $past(col)));

endmodule

// File: rtl/mdet_motion_box.sv
module mdet_motion_box
  import mdet_pkg::*;
#(
  parameter int          PIX_W      = 8,
  parameter int          ROW_W      = 11,
  parameter int          COL_W      = 11,
  parameter int unsigned DEF_THRESH = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_wr,
  input  logic [PIX_W-1:0] thr_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] cur_luma,
  input  logic [PIX_W-1:0] prev_luma,
  input  logic             in_sof,
  input  logic             in_sol,
  input  logic             in_eof,
  output logic             mask_valid,
  input  logic             mask_ready,
  output logic [PIX_W-1:0] mask_data,
  output logic             mask_sof,
  output logic             mask_sol,
  output logic             mask_eof,
  output logic             box_valid,
  output logic             box_none,
  output logic [ROW_W-1:0] box_top,
  output logic [ROW_W-1:0] box_bottom,
  output logic [COL_W-1:0] box_left,
  output logic [COL_W-1:0] box_right
);

  logic             accept;
  logic [PIX_W-1:0] thr;
  logic             hit;
  logic [ROW_W-1:0] pix_row;
  logic [COL_W-1:0] pix_col;
  logic             mask_hit;
  mdet_sync_t       mask_sync;

  assign in_ready = !mask_valid || mask_ready;
  assign accept   = in_valid && in_ready;

  mdet_thr_reg #(.PIX_W(PIX_W), .DEF_THRESH(DEF_THRESH)) u_thr (
    .clk(clk), .rst_n(rst_n), .wr(thr_wr), .wdata(thr_data), .thr(thr)
  );

  mdet_absdiff_thr #(.PIX_W(PIX_W)) u_diff (
    .cur(cur_luma), .prev(prev_luma), .thr(thr), .hit(hit)
  );

  mdet_coord #(.ROW_W(ROW_W), .COL_W(COL_W)) u_coord (
    .clk(clk), .rst_n(rst_n), .step(accept), .sof(in_sof), .sol(in_sol),
    .pix_row(pix_row), .pix_col(pix_col)
  );

  mdet_extent #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .step(accept), .sof(in_sof), .eof(in_eof),
    .hit(hit), .row(pix_row), .col(pix_col),
    .box_valid(box_valid), .box_none(box_none),
    .box_top(box_top), .box_bottom(box_bottom),
    .box_left(box_left), .box_right(box_right)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_valid <= 1'b0;
      mask_hit   <= 1'b0;
      mask_sync  <= '0;
    end else if (accept) begin
      mask_valid <= 1'b1;
      mask_hit   <= hit;
      mask_sync  <= '{sof: in_sof, sol: in_sol, eof: in_eof};
    end else if (mask_ready) begin
      mask_valid <= 1'b0;
    end
  end

  assign mask_data = {PIX_W{mask_hit}};
  assign mask_sof  = mask_sync.sof;
  assign mask_sol  = mask_sync.sol;
  assign mask_eof  = mask_sync.eof;

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_valid && !mask_ready) |=> (mask_valid && $stable(mask_data) && $stable(mask_sof)
                                     && $stable(mask_sol) && $stable(mask_eof)));

  // R4
  mask_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_valid) |-> $past(in_valid && in_ready));

endmodule

// File: tb/test_mdet_motion_box.sv
module test_mdet_motion_box;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int RW = 11;
  localparam int CW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thr_wr = 1'b0;
  logic [PW-1:0] thr_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [PW-1:0] cur_luma = '0, prev_luma = '0;
  logic in_sof = 1'b0, in_sol = 1'b0, in_eof = 1'b0;
  logic mask_valid, mask_ready = 1'b1;
  logic [PW-1:0] mask_data;
  logic mask_sof, mask_sol, mask_eof;
  logic box_valid, box_none;
  logic [RW-1:0] box_top, box_bottom;
  logic [CW-1:0] box_left, box_right;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdet_motion_box #(.PIX_W(PW), .ROW_W(RW), .COL_W(CW), .DEF_THRESH(15)) i_mdet_motion_box (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_data(thr_data),
    .in_valid(in_valid), .in_ready(in_ready), .cur_luma(cur_luma), .prev_luma(prev_luma),
    .in_sof(in_sof), .in_sol(in_sol), .in_eof(in_eof),
    .mask_valid(mask_valid), .mask_ready(mask_ready), .mask_data(mask_data),
    .mask_sof(mask_sof), .mask_sol(mask_sol), .mask_eof(mask_eof),
    .box_valid(box_valid), .box_none(box_none), .box_top(box_top), .box_bottom(box_bottom),
    .box_left(box_left), .box_right(box_right)
  );

  // {cur, prev, threshold, expect_motion}
  localparam logic [31:0] VEC [12] = '{
    {8'd130, 8'd16,  8'd15,  8'd1},
    {8'd16,  8'd130, 8'd15,  8'd1},
    {8'd31,  8'd16,  8'd15,  8'd0},
    {8'd32,  8'd16,  8'd15,  8'd1},
    {8'd0,   8'd255, 8'd15,  8'd1},
    {8'd200, 8'd200, 8'd0,   8'd0},
    {8'd201, 8'd200, 8'd0,   8'd1},
    {8'd100, 8'd160, 8'd60,  8'd0},
    {8'd100, 8'd161, 8'd60,  8'd1},
    {8'd255, 8'd0,   8'd254, 8'd1},
    {8'd255, 8'd0,   8'd255, 8'd0},
    {8'd7,   8'd9,   8'd1,   8'd1}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_thr(input logic [PW-1:0] v);
    @(negedge clk);
    thr_wr = 1'b1;
    thr_data = v;
    @(negedge clk);
    thr_wr = 1'b0;
  endtask

  task automatic send_one(input logic [PW-1:0] c, input logic [PW-1:0] p);
    @(negedge clk);
    in_valid = 1'b1; cur_luma = c; prev_luma = p;
    in_sof = 1'b1; in_sol = 1'b1; in_eof = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic bit is_hit(input int kind, input int r, input int c, input int nr, input int nc);
    case (kind)
      0: return (r == 1 && c == 5) || (r == 3 && c == 2) || (r == 2 && c == 6);
      2: return (r == nr-1 && c == nc-1);
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_frame(input int kind, input int nr, input int nc, input string req);
    int etop = 1 << 20, ebot = -1, elft = 1 << 20, ergt = -1;
    bit any = 0, have = 0;
    bit ph = 0, ps = 0, pl = 0, pe = 0;
    int bad = 0;
    for (int r = 0; r < nr; r++) begin
      for (int c = 0; c < nc; c++) begin
        bit h;
        @(negedge clk);
        if (have && !(mask_valid && mask_data == (ph ? 8'hFF : 8'h00) &&
                      mask_sof == ps && mask_sol == pl && mask_eof == pe)) bad++;
        h = is_hit(kind, r, c, nr, nc);
        in_valid = 1'b1;
        in_sof = (r == 0 && c == 0);
        in_sol = (c == 0);
        in_eof = (r == nr-1 && c == nc-1);
        if (h) begin
          if ((r + c) % 2 == 1) begin cur_luma = 8'd200; prev_luma = 8'd10; end
          else begin cur_luma = 8'd5; prev_luma = 8'd90; end
          any = 1;
          if (r < etop) etop = r;
          if (r > ebot) ebot = r;
          if (c < elft) elft = c;
          if (c > ergt) ergt = c;
        end else begin
          cur_luma = PW'(60 + c);
          prev_luma = (c % 2 == 1) ? PW'(75 + c) : PW'(45 + c);
        end
        ph = h; ps = in_sof; pl = in_sol; pe = in_eof; have = 1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (!(mask_valid && mask_data == (ph ? 8'hFF : 8'h00) && mask_eof == pe)) bad++;
    chk(bad == 0, "R4", "mask per pixel and markers mismatches", bad, 0);
    chk(box_valid == 1'b1, req, "box_valid after eof", box_valid, 1);
    if (!any) begin
      etop = 0; ebot = 0; elft = 0; ergt = 0;
    end
    chk(box_none == !any, any ? "R7" : "R8", "box_none", box_none, !any);
    chk(box_top == etop && box_bottom == ebot, req, "top*1000+bottom",
        box_top * 1000 + box_bottom, etop * 1000 + ebot);
    chk(box_left == elft && box_right == ergt, req, "left*1000+right",
        box_left * 1000 + box_right, elft * 1000 + ergt);
    @(negedge clk);
    chk(box_valid == 1'b0 && box_top == etop && box_right == ergt && box_none == !any,
        "R9", "box strobe drops and outputs hold", box_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mask_valid == 1'b0 && box_valid == 1'b0 && in_ready == 1'b1, "R5",
        "reset state mask_valid/box_valid/in_ready", {mask_valid, box_valid, in_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mask_valid == 1'b0 && box_valid == 1'b0 && box_none == 1'b0, "R9", "post-reset idle",
        {mask_valid, box_valid, box_none}, 0);

    // R3 default threshold of 15
    send_one(8'd16, 8'd0);
    chk(mask_data == 8'hFF && mask_valid, "R3", "default threshold, diff 16", mask_data, 255);
    send_one(8'd15, 8'd0);
    chk(mask_data == 8'h00 && mask_valid, "R3", "default threshold, diff 15", mask_data, 0);
    chk(mask_sof && mask_sol && mask_eof, "R4", "markers follow beat",
        {mask_sof, mask_sol, mask_eof}, 7);

    // R1 R2 R3 vector table
    foreach (VEC[i]) begin
      write_thr(VEC[i][15:8]);
      send_one(VEC[i][31:24], VEC[i][23:16]);
      chk(mask_valid && mask_data == (VEC[i][0] ? 8'hFF : 8'h00),
          (i == 1 || i == 4) ? "R1" : "R2", $sformatf("vector %0d mask", i),
          mask_data, VEC[i][0] ? 255 : 0);
    end

    // R5 back-pressure
    write_thr(8'd15);
    mask_ready = 1'b1;
    send_one(8'd200, 8'd0);
    mask_ready = 1'b0;
    in_valid = 1'b1; cur_luma = 8'd50; prev_luma = 8'd50;
    #1;
    chk(in_ready == 1'b0, "R5", "in_ready low while stalled", in_ready, 0);
    @(negedge clk);
    @(negedge clk);
    chk(mask_valid && mask_data == 8'hFF && in_ready == 1'b0, "R5", "stalled mask held",
        mask_data, 255);
    mask_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(mask_valid && mask_data == 8'h00, "R5", "held beat accepted after release", mask_data, 0);
    repeat (3) @(negedge clk);
    chk(mask_valid == 1'b0 && mask_data == 8'h00, "R5", "idle cycles leave mask unchanged",
        mask_valid, 0);

    // R6 R7 frames
    run_frame(0, 5, 8, "R6");
    run_frame(2, 5, 8, "R9");
    run_frame(1, 4, 6, "R8");
    run_frame(0, 4, 7, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule